// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART Transceiver

This block is a byte-wide UART that can run on one shared open-drain wire. It only ever pulls the line low, through `line_pull_low`. An external resistor pulls the line high at all other times, so the line is released whenever no character is being sent. Characters are sent and received in 8N1 form. Reception uses 16x oversampling with a run-time baud divisor.

In half-duplex mode the block switches direction by itself. At idle the receiver listens and the transmitter is off. The first write turns the transmitter on and sets the receiver according to the readback input. With readback selected, the receiver keeps sampling while the block sends, so every character comes back on the receive port. Any other device that pulls the wire low during a sent '1' shows up as a cleared bit in that echo, which is what bit-banged single-wire sensor buses need. When the transmitter runs dry, the block returns to listening.

In full-duplex mode the two directions are independent. The receiver then takes its data from a separate receive pin.

Top module: `swire_uart`

## Requirements
- R1: After reset in half-duplex mode, the transmitter is off (`tx_ready` low), the receiver is on (a frame arriving on `line_in` is received), and `line_pull_low` is 0. While the transmitter is off the line is never pulled.
- R2: In half-duplex mode with the transmitter off, an asserted `tx_valid` turns the transmitter on at the next clock edge, so `tx_ready` rises one cycle later. The receiver enable is then set from `cfg_readback` (1 = receiver on while sending).
- R3: A frame is sent as `line_pull_low` = 1 for the start bit, then the eight data bits LSB first with `line_pull_low` equal to the inverse of the bit, then `line_pull_low` = 0 for the stop bit. Each bit lasts 16 × `cfg_baud_div` clock cycles, counted from the accepting edge. The line is released after the stop bit.
- R4: With readback on, every sent character appears once on `rx_data` with `rx_valid`. If another device holds the line low during a '1' data bit, that bit reads as 0.
- R5: With readback off, no `rx_valid` occurs during the block's own transmission.
- R6: During a back-to-back burst, the transmitter stays on and `cfg_readback` is not re-sampled. A change in `cfg_readback` takes effect only at the next write that finds the transmitter off.
- R7: When the transmitter is idle and `tx_valid` is low, half-duplex mode returns to transmitter off and receiver on.
- R8: In full-duplex mode (`cfg_half_duplex` = 0), `tx_ready` is high whenever the transmitter is idle. Reception uses `rxd_in` and ignores `line_in`, and both directions run at the same time.
- R9: The receiver takes each bit at its midpoint, 8 oversample ticks after the start edge and then every 16 ticks. A low pulse that is high again at the start-bit midpoint is dropped and produces no `rx_valid`.
- R10: `cfg_baud_div` (0 treated as 1) is captured at each start bit. A change during a frame takes effect at the next start bit.
- R11: `rx_frame_err` is 1 together with `rx_valid` when the sampled stop bit is low, and 0 when it is high.
- R12: `rx_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_duplex | input | 1 | 1 = single shared wire, 0 = separate receive pin |
| cfg_readback | input | 1 | 1 = keep receiving while sending in half-duplex |
| cfg_baud_div | input | DIV_W | Clocks per oversample tick |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte accepted when high with tx_valid |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| rx_frame_err | output | 1 | Stop bit sampled low, valid with rx_valid |
| line_in | input | 1 | Sensed level of the shared wire |
| rxd_in | input | 1 | Receive pin used in full-duplex mode |
| line_pull_low | output | 1 | 1 = pull the wire low (open-drain enable) |

## Verification
The bench builds the block with an 8-bit divisor and 16x oversampling. It runs divisors 1 to 3, so one frame takes 160 to 480 clocks. At that cost, all 256 byte values can be sent through the readback path and all 256 received from a bench-driven wire, each transmitted frame compared bit-period by bit-period against the expected waveform. The short frames also leave room for the direction corner cases: the cycle the transmitter turns on, readback changed inside a burst, collisions on single bits, false starts, stop-bit errors, and a divisor changed mid-frame.

// File: rtl/swire_uart_pkg.sv
package swire_uart_pkg;

  localparam int FRAME_LEN = 10;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // A divisor of zero would stall the prescaler; it is run as one.
  function automatic int unsigned clamp_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // Line levels of a whole frame, bit 0 goes out first.
  function automatic logic [FRAME_LEN-1:0] build_frame(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

endpackage

// File: rtl/swire_prescale.sv
module swire_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import swire_uart_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_l;

  assign tick = run && !restart && (cnt == div_l - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_l <= DIV_W'(1);
    end else if (restart) begin
      cnt   <= '0;
      div_l <= DIV_W'(clamp_div(32'(div)));
    end else if (run) begin
      cnt <= tick ? '0 : cnt + DIV_W'(1);
    end else begin
      cnt <= '0;
    end
  end

  // R10: rate held for the whole frame once captured
  p_div_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && $past(run) && !$past(restart)) |-> $stable(div_l));

endmodule

// File: rtl/swire_tx.sv
module swire_tx #(
  parameter int DIV_W = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             enable,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             busy,
  output logic             drive_low
);
  import swire_uart_pkg::*;

  localparam int OSR_W = $clog2(OSR);
  localparam logic [OSR_W-1:0] OSR_LAST = OSR_W'(OSR - 1);
  localparam logic [3:0] LAST_BIT = 4'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [3:0]           bit_idx;
  logic [OSR_W-1:0]     osr_cnt;
  logic                 tick;
  logic                 accept;
  logic                 bit_adv;
  logic                 frame_end;

  assign tx_ready  = enable && !busy;
  assign accept    = tx_valid && tx_ready;
  assign bit_adv   = busy && tick && (osr_cnt == OSR_LAST);
  assign frame_end = bit_adv && (bit_idx == LAST_BIT);

  swire_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy), .div(div), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      drive_low <= 1'b0;
      shreg     <= '1;
      bit_idx   <= '0;
      osr_cnt   <= '0;
    end else if (accept) begin
      shreg     <= build_frame(tx_data);
      drive_low <= 1'b1;
      busy      <= 1'b1;
      bit_idx   <= '0;
      osr_cnt   <= '0;
    end else if (busy && tick) begin
      if (osr_cnt == OSR_LAST) begin
        osr_cnt <= '0;
        if (frame_end) begin
          busy      <= 1'b0;
          drive_low <= 1'b0;
        end else begin
          bit_idx   <= bit_idx + 4'd1;
          shreg     <= {1'b1, shreg[FRAME_LEN-1:1]};
          drive_low <= !shreg[1];
        end
      end else begin
        osr_cnt <= osr_cnt + OSR_W'(1);
      end
    end
  end

  // R3: line released outside a frame
  p_release_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_low);
  // R3: every frame opens with a low start bit
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> drive_low);
  // R3: level only moves at a bit boundary
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_adv)) |-> $stable(drive_low));

endmodule

// File: rtl/swire_rx.sv
module swire_rx #(
  parameter int DIV_W = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             enable,
  input  logic             line,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             frame_err
);
  import swire_uart_pkg::*;

  localparam int OSR_W = $clog2(OSR);
  localparam logic [OSR_W-1:0] MID_LAST = OSR_W'(OSR / 2 - 1);
  localparam logic [OSR_W-1:0] OSR_LAST = OSR_W'(OSR - 1);

  rx_state_e        state;
  logic [1:0]       sync;
  logic             s;
  logic             prev;
  logic [OSR_W-1:0] osr_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             tick;
  logic             start_seen;
  logic             mid_start;
  logic             false_start;
  logic             bit_point;

  assign s           = sync[1];
  assign start_seen  = enable && (state == RX_IDLE) && prev && !s;
  assign mid_start   = (state == RX_START) && tick && (osr_cnt == MID_LAST);
  assign false_start = mid_start && s;
  assign bit_point   = ((state == RX_DATA) || (state == RX_STOP)) && tick && (osr_cnt == OSR_LAST);

  swire_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start_seen), .run(state != RX_IDLE),
    .div(div), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      prev <= 1'b1;
    end else begin
      sync <= {sync[0], line};
      prev <= s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      osr_cnt   <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: begin
            if (start_seen) begin
              state   <= RX_START;
              osr_cnt <= '0;
            end
          end
          RX_START: begin
            if (mid_start) begin
              osr_cnt <= '0;
              bit_idx <= '0;
              state   <= false_start ? RX_IDLE : RX_DATA;
            end else if (tick) begin
              osr_cnt <= osr_cnt + OSR_W'(1);
            end
          end
          RX_DATA: begin
            if (bit_point) begin
              osr_cnt <= '0;
              shreg   <= {s, shreg[7:1]};
              bit_idx <= bit_idx + 3'd1;
              if (bit_idx == 3'd7) state <= RX_STOP;
            end else if (tick) begin
              osr_cnt <= osr_cnt + OSR_W'(1);
            end
          end
          RX_STOP: begin
            if (bit_point) begin
              rx_valid  <= 1'b1;
              rx_data   <= shreg;
              frame_err <= !s;
              state     <= RX_IDLE;
            end else if (tick) begin
              osr_cnt <= osr_cnt + OSR_W'(1);
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R12: one-cycle byte pulse
  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5: nothing delivered by a disabled receiver
  p_enabled_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(enable));
  // R9: a rejected start leaves the receiver idle with no output
  p_false_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (false_start && enable) |=> (state == RX_IDLE) && !rx_valid);

endmodule

// File: rtl/swire_dir_ctl.sv
module swire_dir_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic half,
  input  logic readback,
  input  logic tx_valid,
  input  logic tx_busy,
  output logic tx_en,
  output logic rx_en
);
  logic tx_on;
  logic rx_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on <= 1'b0;
      rx_on <= 1'b1;
    end else if (!half) begin
      tx_on <= 1'b0;
      rx_on <= 1'b1;
    end else if (!tx_on && tx_valid) begin
      tx_on <= 1'b1;
      rx_on <= readback;
    end else if (tx_on && !tx_busy && !tx_valid) begin
      tx_on <= 1'b0;
      rx_on <= 1'b1;
    end
  end

  assign tx_en = !half || tx_on;
  assign rx_en = !half || rx_on;

  // R2: receiver setting taken from readback when the transmitter turns on
  p_take_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half && $rose(tx_on)) |-> (rx_on == $past(readback)));
  // R1: with the transmitter off the receiver listens
  p_idle_listens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> rx_on);
  // R6: receiver setting frozen while the transmitter stays on
  p_burst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (half && $past(half) && tx_on && $past(tx_on)) |-> $stable(rx_on));

endmodule

// File: rtl/swire_uart.sv
module swire_uart #(
  parameter int DIV_W = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_half_duplex,
  input  logic             cfg_readback,
  input  logic [DIV_W-1:0] cfg_baud_div,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_frame_err,
  input  logic             line_in,
  input  logic             rxd_in,
  output logic             line_pull_low
);
  logic tx_en_w;
  logic rx_en_w;
  logic tx_busy_w;
  logic rx_src_w;

  assign rx_src_w = cfg_half_duplex ? line_in : rxd_in;

  swire_dir_ctl u_dir (
    .clk(clk), .rst_n(rst_n), .half(cfg_half_duplex), .readback(cfg_readback),
    .tx_valid(tx_valid), .tx_busy(tx_busy_w), .tx_en(tx_en_w), .rx_en(rx_en_w)
  );

  swire_tx #(.DIV_W(DIV_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(cfg_baud_div), .enable(tx_en_w),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .busy(tx_busy_w), .drive_low(line_pull_low)
  );

  swire_rx #(.DIV_W(DIV_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(cfg_baud_div), .enable(rx_en_w),
    .line(rx_src_w), .rx_valid(rx_valid), .rx_data(rx_data), .frame_err(rx_frame_err)
  );

  // R2: a frame never starts while the transmitter is switched off
  p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy_w) |-> $past(tx_en_w));
  // R1: no pull on the wire while the transmitter is off
  p_released_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_w |-> !line_pull_low);

endmodule

// File: tb/test_swire_uart.sv
module test_swire_uart;
  localparam int DIV_W = 8;
  localparam int OSR   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_half_duplex = 1'b1;
  logic cfg_readback = 1'b0;
  logic [DIV_W-1:0] cfg_baud_div = 8'd1;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, rx_frame_err, line_pull_low;
  logic [7:0] rx_data;
  logic dev_pull = 1'b0;
  logic rxd_drv = 1'b1;
  logic line_in;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int pulse_bad = 0;
  logic [7:0] rx_last = 8'h00;
  logic rx_err_last = 1'b0;
  logic prev_valid = 1'b0;

  assign line_in = !(line_pull_low || dev_pull);

  always #4 clk = !clk;

  swire_uart #(.DIV_W(DIV_W), .OSR(OSR)) i_swire_uart (
    .clk(clk), .rst_n(rst_n), .cfg_half_duplex(cfg_half_duplex), .cfg_readback(cfg_readback),
    .cfg_baud_div(cfg_baud_div), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .line_in(line_in), .rxd_in(rxd_drv), .line_pull_low(line_pull_low)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
      rx_err_last = rx_frame_err;
    end
    if (rx_valid && prev_valid) pulse_bad++;
    prev_valid = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected pull level of bit slot i for byte b: slot 0 start, slots 1..8 data, slot 9 stop.
  function automatic logic want_pull(input logic [7:0] b, input int i);
    if (i == 0) return 1'b1;
    if (i >= 9) return 1'b0;
    return (((b >> (i - 1)) & 8'h01) == 8'h00);
  endfunction

  task automatic wait_accept();
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic tx_and_watch(input logic [7:0] b, input int d, output int bad);
    bad = 0;
    tx_data = b;
    tx_valid = 1'b1;
    wait_accept();
    tx_valid = 1'b0;
    for (int k = 1; k <= 160 * d; k++) begin
      @(negedge clk);
      if (line_pull_low !== want_pull(b, (k - 1) / (16 * d))) bad++;
    end
    @(negedge clk);
    if (line_pull_low !== 1'b0) bad++;
  endtask

  task automatic dev_frame(input logic [7:0] b, input int d, input bit stop_ok, input bit on_rxd);
    for (int i = 0; i < 10; i++) begin
      logic lvl;
      lvl = (i == 0) ? 1'b0 : (i == 9) ? stop_ok : b[i-1];
      @(posedge clk);
      #1;
      if (on_rxd) rxd_drv = lvl; else dev_pull = !lvl;
      repeat (16 * d - 1) @(posedge clk);
    end
    @(posedge clk);
    #1;
    rxd_drv = 1'b1;
    dev_pull = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad, base, tot_bad, tot_rx_bad, len;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(tx_ready == 1'b0, "R1 tx_ready at idle", tx_ready, 0);
    chk(line_pull_low == 1'b0, "R1 line released", line_pull_low, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    base = rx_cnt;
    dev_frame(8'hC3, 1, 1, 0);
    idle(4);
    chk(rx_cnt == base + 1 && rx_last == 8'hC3, "R1 receiver on at idle", rx_last, 8'hC3);

    // R2 transmitter turns on one cycle after valid
    @(posedge clk);
    #1 tx_data = 8'h96; tx_valid = 1'b1; cfg_readback = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R2 ready still low", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R2 ready one cycle later", tx_ready, 1);
    @(posedge clk);
    #1 tx_valid = 1'b0;
    base = rx_cnt;
    idle(170);
    chk(rx_cnt == base + 1 && rx_last == 8'h96, "R2 readback set from cfg_readback", rx_last, 8'h96);

    // R3/R4 exhaustive readback sweep at divisor 1
    tot_bad = 0;
    tot_rx_bad = 0;
    for (int v = 0; v < 256; v++) begin
      base = rx_cnt;
      tx_and_watch(8'(v), 1, bad);
      tot_bad += bad;
      idle(2);
      if (rx_cnt != base + 1 || rx_last != 8'(v) || rx_err_last) tot_rx_bad++;
    end
    chk(tot_bad == 0, "R3 frame waveform sweep", tot_bad, 0);
    chk(tot_rx_bad == 0, "R4 readback sweep", tot_rx_bad, 0);
    // R7 idle return
    chk(tx_ready == 1'b0, "R7 transmitter off after write", tx_ready, 0);

    // R3 at slower divisors
    cfg_baud_div = 8'd2;
    tx_and_watch(8'hA5, 2, bad);
    chk(bad == 0, "R3 frame at divisor 2", bad, 0);
    cfg_baud_div = 8'd3;
    tx_and_watch(8'h3C, 3, bad);
    chk(bad == 0, "R3 frame at divisor 3", bad, 0);

    // R4 collision on data bit 3
    cfg_baud_div = 8'd2;
    idle(4);
    base = rx_cnt;
    fork
      tx_and_watch(8'hFF, 2, bad);
      begin
        wait (line_pull_low == 1'b1);
        repeat (4 * 32 + 8) @(posedge clk);
        #1 dev_pull = 1'b1;
        repeat (16) @(posedge clk);
        #1 dev_pull = 1'b0;
      end
    join
    idle(2);
    chk(rx_cnt == base + 1 && rx_last == 8'hF7, "R4 collision visible", rx_last, 8'hF7);

    // R5 no readback
    cfg_readback = 1'b0;
    cfg_baud_div = 8'd1;
    idle(4);
    base = rx_cnt;
    tx_and_watch(8'h5A, 1, bad);
    idle(20);
    chk(rx_cnt == base, "R5 no echo", rx_cnt - base, 0);
    // R7 receiver back on afterwards
    dev_frame(8'h1E, 1, 1, 0);
    idle(4);
    chk(rx_cnt == base + 1 && rx_last == 8'h1E, "R7 receiver on after write", rx_last, 8'h1E);

    // R6 burst with readback changed after the first accept
    cfg_readback = 1'b1;
    idle(4);
    base = rx_cnt;
    tx_data = 8'h11;
    tx_valid = 1'b1;
    wait_accept();
    tx_data = 8'h22;
    cfg_readback = 1'b0;
    wait_accept();
    tx_data = 8'h33;
    wait_accept();
    tx_valid = 1'b0;
    idle(200);
    chk(rx_cnt == base + 3 && rx_last == 8'h33, "R6 burst keeps readback", rx_cnt - base, 3);
    base = rx_cnt;
    tx_and_watch(8'h44, 1, bad);
    idle(10);
    chk(rx_cnt == base, "R6 new readback at next write", rx_cnt - base, 0);

    // R10 divisor change mid-frame
    cfg_baud_div = 8'd2;
    tx_data = 8'h01;
    tx_valid = 1'b1;
    wait_accept();
    tx_valid = 1'b0;
    cfg_baud_div = 8'd3;
    len = 0;
    forever begin
      @(negedge clk);
      if (!line_pull_low) break;
      len++;
    end
    chk(len == 32, "R10 start bit keeps old rate", len, 32);
    idle(400);
    tx_data = 8'h01;
    tx_valid = 1'b1;
    wait_accept();
    tx_valid = 1'b0;
    len = 0;
    forever begin
      @(negedge clk);
      if (!line_pull_low) break;
      len++;
    end
    chk(len == 48, "R10 next frame uses new rate", len, 48);
    idle(500);

    // R9 false start then a real frame at divisor 2
    cfg_baud_div = 8'd2;
    base = rx_cnt;
    @(posedge clk);
    #1 dev_pull = 1'b1;
    repeat (10) @(posedge clk);
    #1 dev_pull = 1'b0;
    idle(400);
    chk(rx_cnt == base, "R9 short pulse dropped", rx_cnt - base, 0);
    dev_frame(8'h6D, 2, 1, 0);
    idle(4);
    chk(rx_cnt == base + 1 && rx_last == 8'h6D, "R9 midpoint sampling", rx_last, 8'h6D);

    // R9 exhaustive receive sweep at divisor 1
    cfg_baud_div = 8'd1;
    tot_rx_bad = 0;
    for (int v = 0; v < 256; v++) begin
      base = rx_cnt;
      dev_frame(8'(v), 1, 1, 0);
      idle(3);
      if (rx_cnt != base + 1 || rx_last != 8'(v) || rx_err_last) tot_rx_bad++;
    end
    chk(tot_rx_bad == 0, "R9 receive sweep", tot_rx_bad, 0);

    // R11 framing error then recovery
    base = rx_cnt;
    dev_frame(8'h3C, 1, 0, 0);
    idle(2);
    chk(rx_cnt == base + 1 && rx_err_last == 1'b1, "R11 low stop flagged", rx_err_last, 1);
    idle(30);
    dev_frame(8'hC5, 1, 1, 0);
    idle(3);
    chk(rx_last == 8'hC5 && rx_err_last == 1'b0, "R11 good stop clear", rx_err_last, 0);

    // R8 full duplex: separate receive pin, simultaneous directions
    cfg_half_duplex = 1'b0;
    idle(3);
    chk(tx_ready == 1'b1, "R8 ready at idle", tx_ready, 1);
    base = rx_cnt;
    fork
      tx_and_watch(8'h81, 1, bad);
      dev_frame(8'h7E, 1, 1, 1);
    join
    idle(4);
    chk(bad == 0, "R8 transmit unaffected", bad, 0);
    chk(rx_cnt == base + 1 && rx_last == 8'h7E, "R8 receive from rxd_in", rx_last, 8'h7E);

    // R12 pulse width
    chk(pulse_bad == 0, "R12 single-cycle rx_valid", pulse_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule